// File: doc/BRIEF.md
# Power Amplifier Ramp Profile Generator

This block stores a set of power-amplifier ramp shapes and plays one of them out to a 10-bit D/A converter. Thirty-two shapes are held: sixteen for rising ramps and sixteen for falling ramps. Each shape has sixteen 8-bit unsigned points. Rising shapes climb from 0 towards 255. Falling shapes drop from 255 towards 0.

Before a ramp, the processor picks a shape index, a direction and two 10-bit gains. Points 0 to 7 of the shape take the left gain and points 8 to 15 take the right gain. A start pulse captures all of these settings and begins the ramp. The block scales every point and keeps the upper ten bits of each product. It then produces 32 output words: each scaled point is followed by the midpoint between it and its successor. A programmable divider paces the words, and each new word comes with a one-cycle strobe. Between ramps the converter word holds its last value.

Top module: `pa_ramp_gen`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `dacStrobe` are 0 and `dacWord` is 0.
- R2: A start pulse sampled while idle raises `busy` on the same clock edge. The first `dacStrobe` is asserted one cycle after that edge, and `busy` is 1 while it is present.
- R3: A stored point e is scaled as floor(e*g/256), the upper 10 bits of the 18-bit product. Point indices 0..7 use `gainLeft` and indices 8..15 use `gainRight`. A point of 255 with a gain of 1023 gives 1019.
- R4: Output word 2k, for k = 0..15, equals scaled point k.
- R5: Output word 2k+1, for k = 0..14, equals floor((scaled k + scaled k+1)/2). Word 31 equals scaled point 15.
- R6: Consecutive strobes are exactly `rateDiv`+1 cycles apart, and each strobe lasts one cycle.
- R7: A ramp issues exactly 32 strobes. `busy` falls on the same edge that issues the 32nd word.
- R8: A start pulse arriving while `busy` is 1 is ignored. The running ramp keeps its settings, its sequence and its timing.
- R9: After a ramp ends, `dacWord` holds word 31 and no strobe occurs until the next start.
- R10: A memory write stores `wrData` at `wrAddr`. Bit 8 of the address selects the bank (0 = rising, 1 = falling), bits 7:4 select the shape and bits 3:0 select the point. `rampDown` and `profileSel` at start choose the bank and shape that are played.
- R11: Changes to `profileSel`, `rampDown`, the gains or `rateDiv` after the start pulse do not affect the running ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Shape memory write enable |
| wrAddr | input | 9 | Write address {bank, shape, point} |
| wrData | input | 8 | Point value to store |
| startPulse | input | 1 | Starts a ramp when idle |
| profileSel | input | 4 | Shape index |
| rampDown | input | 1 | 1 selects the falling bank |
| gainLeft | input | 10 | Gain for points 0..7 |
| gainRight | input | 10 | Gain for points 8..15 |
| rateDiv | input | 8 | Spacing between words minus one, in cycles |
| busy | output | 1 | Ramp in progress |
| dacWord | output | 10 | Converter word |
| dacStrobe | output | 1 | One-cycle pulse marking a new word |

## Verification
The start edge is taken as cycle s. Word i is due in cycle s+1+i*(rateDiv+1), because the issue decision and the output register add one edge. `busy` must read 0 in the cycle of word 31. The bench samples on falling edges and stamps each strobe with a cycle count taken from the same edge. It compares every stamp against that formula and every word against a model built from the scaling and midpoint rules. After the ramp it watches a quiet window to confirm the final word is held.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  parameter int ENTRIES = 16;
  localparam int POINTS = 2 * ENTRIES;
  localparam int IDX_W  = $clog2(POINTS);

  // strobes from control to datapath
  typedef struct packed {
    logic             latch;     // capture settings
    logic             issue;     // register next output word
    logic [IDX_W-1:0] pointIdx;  // output word being produced
  } ramp_ctl_t;
endpackage

// File: rtl/ramp_scale.sv
module ramp_scale #(
  parameter int ENTRY_W = 8,
  parameter int GAIN_W  = 10,
  parameter int DAC_W   = 10
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [GAIN_W-1:0]  gain,
  output logic [DAC_W-1:0]   scaled
);
  localparam int PW = ENTRY_W + GAIN_W;
  logic [PW-1:0] prod;
  assign prod   = {{GAIN_W{1'b0}}, entry} * {{ENTRY_W{1'b0}}, gain};
  // keep the top DAC_W bits of the product
  assign scaled = DAC_W'(prod >> (PW - DAC_W));
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [DIV_W-1:0] rateDiv,
  output ramp_ctl_t        ctl,
  output logic             busy
);
  logic             busyQ;
  logic [DIV_W-1:0] cntQ, divQ;
  logic [IDX_W-1:0] idxQ;
  logic             latch, issue;

  assign latch = startPulse && !busyQ;
  assign issue = busyQ && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      divQ  <= '0;
      idxQ  <= '0;
    end else if (latch) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
      divQ  <= rateDiv;
      idxQ  <= '0;
    end else if (busyQ) begin
      if (cntQ == '0) begin
        cntQ <= divQ;
        idxQ <= idxQ + 1'b1;
        if (idxQ == IDX_W'(POINTS - 1)) busyQ <= 1'b0;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign ctl.latch    = latch;
  assign ctl.issue    = issue;
  assign ctl.pointIdx = idxQ;
  assign busy         = busyQ;

  assert_first_point_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (idxQ == '0 && cntQ == '0));
  assert_index_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0) |=> (idxQ == $past(idxQ)));
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && idxQ == IDX_W'(POINTS - 1)) |=> !busyQ);
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startPulse && !issue) |=> (busyQ && $stable(divQ) && $stable(idxQ)));
endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int PROFILES = 16,
  parameter int ENTRY_W  = 8,
  parameter int GAIN_W   = 10,
  parameter int DAC_W    = 10,
  localparam int PROF_W  = $clog2(PROFILES),
  localparam int KW      = $clog2(ENTRIES),
  localparam int ADDR_W  = 1 + PROF_W + KW,
  localparam int DEPTH   = 2 * PROFILES * ENTRIES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic [PROF_W-1:0]  profileSel,
  input  logic               rampDown,
  input  logic [GAIN_W-1:0]  gainLeft,
  input  logic [GAIN_W-1:0]  gainRight,
  input  ramp_ctl_t          ctl,
  output logic [DAC_W-1:0]   dacWord,
  output logic               dacStrobe
);
  logic [ENTRY_W-1:0] memQ [DEPTH];
  logic [PROF_W:0]    bankQ;
  logic [GAIN_W-1:0]  gainLQ, gainRQ;
  logic [DAC_W-1:0]   dacWordQ;
  logic               strobeQ;

  always_ff @(posedge clk) begin
    if (wrEn) memQ[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= '0;
      gainLQ <= '0;
      gainRQ <= '0;
    end else if (ctl.latch) begin
      bankQ  <= {rampDown, profileSel};
      gainLQ <= gainLeft;
      gainRQ <= gainRight;
    end
  end

  // lane 0 reads point k, lane 1 reads its successor (clamped at the end)
  logic [KW-1:0]    kLo, kHi;
  logic [DAC_W-1:0] laneVal [2];
  assign kLo = ctl.pointIdx[IDX_W-1:1];
  assign kHi = (kLo == KW'(ENTRIES - 1)) ? kLo : kLo + 1'b1;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [KW-1:0]     k;
    logic [ADDR_W-1:0] a;
    logic [GAIN_W-1:0] gn;
    assign k  = (g == 0) ? kLo : kHi;
    assign a  = {bankQ, k};
    assign gn = k[KW-1] ? gainRQ : gainLQ;
    ramp_scale #(.ENTRY_W(ENTRY_W), .GAIN_W(GAIN_W), .DAC_W(DAC_W)) u_scale (
      .entry (memQ[a]),
      .gain  (gn),
      .scaled(laneVal[g])
    );
  end

  logic [DAC_W:0]   pairSum;
  logic [DAC_W-1:0] pointVal;
  assign pairSum  = {1'b0, laneVal[0]} + {1'b0, laneVal[1]};
  assign pointVal = ctl.pointIdx[0] ? DAC_W'(pairSum >> 1) : laneVal[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacWordQ <= '0;
      strobeQ  <= 1'b0;
    end else begin
      strobeQ <= ctl.issue;
      if (ctl.issue) dacWordQ <= pointVal;
    end
  end

  assign dacWord   = dacWordQ;
  assign dacStrobe = strobeQ;

  assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.issue |=> $stable(dacWordQ));
  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.issue |=> !strobeQ);
endmodule

// File: rtl/pa_ramp_gen.sv
module pa_ramp_gen
  import ramp_pkg::*;
#(
  parameter int PROFILES = 16,
  parameter int ENTRY_W  = 8,
  parameter int GAIN_W   = 10,
  parameter int DAC_W    = 10,
  parameter int DIV_W    = 8,
  localparam int PROF_W  = $clog2(PROFILES),
  localparam int ADDR_W  = 1 + PROF_W + $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  input  logic               startPulse,
  input  logic [PROF_W-1:0]  profileSel,
  input  logic               rampDown,
  input  logic [GAIN_W-1:0]  gainLeft,
  input  logic [GAIN_W-1:0]  gainRight,
  input  logic [DIV_W-1:0]   rateDiv,
  output logic               busy,
  output logic [DAC_W-1:0]   dacWord,
  output logic               dacStrobe
);
  ramp_ctl_t ctl;

  ramp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .rateDiv   (rateDiv),
    .ctl       (ctl),
    .busy      (busy)
  );

  ramp_datapath #(
    .PROFILES(PROFILES), .ENTRY_W(ENTRY_W), .GAIN_W(GAIN_W), .DAC_W(DAC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .profileSel(profileSel),
    .rampDown  (rampDown),
    .gainLeft  (gainLeft),
    .gainRight (gainRight),
    .ctl       (ctl),
    .dacWord   (dacWord),
    .dacStrobe (dacStrobe)
  );
endmodule

// File: tb/sim_pa_ramp_gen.sv
module sim_pa_ramp_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       startPulse = 1'b0;
  logic [3:0] profileSel = '0;
  logic       rampDown = 1'b0;
  logic [9:0] gainLeft = '0, gainRight = '0;
  logic [7:0] rateDiv = '0;
  logic       busy, dacStrobe;
  logic [9:0] dacWord;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pa_ramp_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startPulse(startPulse), .profileSel(profileSel), .rampDown(rampDown),
    .gainLeft(gainLeft), .gainRight(gainRight), .rateDiv(rateDiv),
    .busy(busy), .dacWord(dacWord), .dacStrobe(dacStrobe)
  );

  typedef struct packed {
    logic [3:0] sel;
    logic       dir;
    logic [9:0] gL;
    logic [9:0] gR;
    logic [7:0] div;
    logic       inject;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t [NV-1:0] VECS = '{
    '{sel:4'd3,  dir:1'b0, gL:10'd1023, gR:10'd512,  div:8'd2, inject:1'b0},
    '{sel:4'd3,  dir:1'b1, gL:10'd700,  gR:10'd1023, div:8'd0, inject:1'b0},
    '{sel:4'd15, dir:1'b0, gL:10'd1023, gR:10'd1023, div:8'd1, inject:1'b0},
    '{sel:4'd9,  dir:1'b1, gL:10'd0,    gR:10'd1023, div:8'd3, inject:1'b1},
    '{sel:4'd0,  dir:1'b0, gL:10'd256,  gR:10'd100,  div:8'd5, inject:1'b0}
  };

  // stored point contents (bank, shape, point); rising shape 15 is all 255
  function automatic int ent(int d, int p, int e);
    if (d == 0 && p == 15) return 255;
    return (e * 29 + p * 53 + d * 111 + e * e * 3) % 256;
  endfunction

  function automatic int scl(int e, int g);
    return (e * g) / 256;
  endfunction

  function automatic int expPoint(vec_t v, int idx);
    int k, k2, s1, s2;
    k  = idx / 2;
    k2 = (k == 15) ? 15 : k + 1;
    s1 = scl(ent(v.dir, v.sel, k),  (k  < 8) ? int'(v.gL) : int'(v.gR));
    s2 = scl(ent(v.dir, v.sel, k2), (k2 < 8) ? int'(v.gL) : int'(v.gR));
    return (idx % 2 == 1) ? (s1 + s2) / 2 : s1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runRamp(vec_t v);
    int s, t, g, badVal, badTime, busyHi, lastExp, quietBad;
    badVal = 0; badTime = 0; busyHi = 1; lastExp = 0; quietBad = 0;
    @(negedge clk);
    profileSel = v.sel; rampDown = v.dir; gainLeft = v.gL; gainRight = v.gR;
    rateDiv = v.div; startPulse = 1'b1;
    @(negedge clk);
    s = cyc;
    startPulse = 1'b0;
    // R11: scramble settings once the ramp has started
    profileSel = v.sel ^ 4'd5; rampDown = ~v.dir;
    gainLeft = ~v.gL; gainRight = v.gR ^ 10'h155; rateDiv = v.div + 8'd7;
    for (int i = 0; i < 32; i++) begin
      g = 0;
      while (!dacStrobe && g < 2000) begin
        @(negedge clk);
        startPulse = 1'b0;
        g++;
      end
      t = cyc;
      if (t != s + 1 + i * (int'(v.div) + 1)) begin
        if (badTime == 0)
          $display("FAIL R6 word %0d cycle actual=%0d expected=%0d", i, t - s, 1 + i * (int'(v.div) + 1));
        badTime++;
      end
      lastExp = expPoint(v, i);
      if (int'(dacWord) != lastExp) begin
        $display("FAIL %s word %0d actual=%0d expected=%0d",
                 (i % 2 == 1) ? "R5" : "R4", i, dacWord, lastExp);
        badVal++;
      end
      if (i == 0 && !busy) busyHi = 0;
      if (i == 31) check(busy == 1'b0, "R7 busy after word 31", busy, 0);
      // R8: start request with other settings while busy
      if (v.inject && i == 4) begin
        startPulse = 1'b1; profileSel = 4'd1; rampDown = 1'b0;
        gainLeft = 10'd1023; gainRight = 10'd1; rateDiv = 8'd0;
      end
      if (i < 31) begin
        @(negedge clk);
        startPulse = 1'b0;
      end
    end
    check(busyHi == 1, "R2 busy at first word", busyHi, 1);
    check(badTime == 0, v.inject ? "R8 timing" : "R6 timing", badTime, 0);
    check(badVal == 0, v.inject ? "R8 values" : "R3/R4/R5/R10/R11 values", badVal, 0);
    // R9: word held and no strobe afterwards
    for (int q = 0; q < 12; q++) begin
      @(negedge clk);
      if (dacStrobe || busy || int'(dacWord) != lastExp) quietBad++;
    end
    check(quietBad == 0, "R9 hold after ramp", int'(dacWord), lastExp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && dacStrobe == 0 && dacWord == 0, "R1 reset state", {busy, dacStrobe, dacWord}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && dacStrobe == 0 && dacWord == 0, "R1 after reset", {busy, dacStrobe, dacWord}, 0);
    // R10: load memory, address = {bank, shape, point}
    for (int a = 0; a < 512; a++) begin
      wrEn = 1'b1; wrAddr = 9'(a); wrData = 8'(ent(a >> 8, (a >> 4) & 15, a & 15));
      @(negedge clk);
    end
    wrEn = 1'b0;
    // R3: full-scale point with full-scale gain
    check(scl(255, 1023) == 1019, "R3 model full scale", scl(255, 1023), 1019);
    for (int n = 0; n < NV; n++) runRamp(VECS[n]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule